// File: doc/BRIEF.md
# Subranging Two-Pass Code Merger

This block sits after the sequencer of a two-pass subranging converter. The sequencer delivers a 9-bit coarse code from the first pass and a 9-bit fine code from the second pass. The fine pass spans only a quarter of the flash range, so the two codes overlap by two bits. The block adds them with that overlap rather than concatenating them, which absorbs first-pass and amplifier error into the fine code. The block then forms one 16-bit word, clamps any result that lies outside the 16-bit span, and flags the clamp on an active-low range flag.

The merged word is computed as `coarse * 128 + fine - 128`. This sum is evaluated in 18 signed bits. A negative sum clamps to 0x0000, and a sum above 65535 clamps to 0xFFFF. The native coding is offset binary, or straight binary on a unipolar range: all zeros sit at the negative end, all ones at the positive end, and mid-code at zero input. A select input latched with each conversion gives two's complement instead, by inverting the word's top bit. A separate output always carries the inverse of the native top bit.

The result is read over an 8-bit-wide bus through two lanes, each gated by its own active-low enable. The lanes are modelled as data plus an output-enable bit. A small control state machine with the states `ST_IDLE` and `ST_PULSE` loads the output registers on the strobe and drives a one-cycle transfer pulse. The transition from `ST_IDLE` to `ST_PULSE` is taken on a strobe. `ST_PULSE` stays in `ST_PULSE` if a strobe arrives in that cycle and otherwise returns to `ST_IDLE`.

Top module: `adc_subrange_merge`

## Requirements
- R1: On a strobe, the word is formed as `coarse*128 + fine - 128` when that value lies in 0..65535.
- R2: When the sum exceeds 65535, the native word is 0xFFFF and the range flag is 0.
- R3: When the sum is negative, the native word is 0x0000 and the range flag is 0.
- R4: When the sum lies in 0..65535, the range flag is 1. This includes the sums 0 and 65535 exactly. Any coarse code from 1 to 509 never clamps.
- R5: If the coding select is 0 at the strobe, `result` is the native offset-binary word. If it is 1, bit 15 of `result` is inverted, which gives two's complement.
- R6: `msb_cmp` is the inverse of bit 15 of the native word, whatever the coding select.
- R7: `result`, `msb_cmp` and `ovr_n` are loaded together at the clock edge where `conv_stb` is 1, and they hold when `conv_stb` is 0.
- R8: `xfer_pulse` is 1 in exactly the cycle after each strobe and 0 otherwise.
- R9: When `hi_en_n` is 0, `hi_oe` is 1 and `hi_lane` equals `{msb_cmp, result[15:8]}`. When `hi_en_n` is 1, `hi_oe` is 0 and `hi_lane` reads 0.
- R10: When `lo_en_n` is 0, `lo_oe` is 1 and `lo_lane` equals `result[7:0]`. When `lo_en_n` is 1, `lo_oe` is 0 and `lo_lane` reads 0.
- R11: After reset, `result` is 0x0000, `msb_cmp` is 1, `ovr_n` is 1 and `xfer_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_stb | input | 1 | Both pass codes are valid this cycle |
| coarse_code | input | 9 | First-pass code |
| fine_code | input | 9 | Second-pass code, centred on mid-span |
| twos_sel | input | 1 | 1 selects two's complement output coding |
| hi_en_n | input | 1 | Upper lane enable, active low |
| lo_en_n | input | 1 | Lower lane enable, active low |
| result | output | 16 | Merged word in the selected coding |
| msb_cmp | output | 1 | Inverse of the native top bit |
| ovr_n | output | 1 | 0 when the last result was clamped |
| xfer_pulse | output | 1 | One-cycle pulse after each load |
| hi_lane | output | 9 | Upper lane data: complement bit and upper byte |
| hi_oe | output | 1 | Upper lane driving |
| lo_lane | output | 8 | Lower lane data: lower byte |
| lo_oe | output | 1 | Lower lane driving |

## Verification
The bench runs every coarse code against a set of fine codes that includes 0, 127, 128, 129, 383, 384 and 511, plus one pattern that steps with the coarse code. This reaches the exact sums 0 and 65535 and the first sums on either side of them. A merger that concatenated the codes, used the wrong offset or compared with the wrong width would get the word wrong across this sweep. One that flagged the boundary sums, or wrapped instead of clamping, would fail at coarse codes 0, 510 and 511. The bench also toggles the coding select and the two lane enables between conversions, and changes the codes in the idle cycle. This catches a top bit inverted on the wrong select, lanes that drive while disabled, and registers that load without a strobe.

// File: rtl/adc_merge_pkg.sv
package adc_merge_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } xfer_state_t;
endpackage

// File: rtl/adc_merge_sum.sv
// Overlapped addition of the coarse and fine pass codes with clamping.
module adc_merge_sum #(
    parameter int CW = 9,
    parameter int FW = 9,
    parameter int OW = 16
) (
    input  logic [CW-1:0] coarse,
    input  logic [FW-1:0] fine,
    output logic [OW-1:0] native,
    output logic          clamped
);
    localparam int SH = OW - CW;
    localparam int SW = OW + 2;
    localparam logic signed [SW-1:0] OFFS_V = SW'(1) << SH;
    localparam logic signed [SW-1:0] MAX_V  = (SW'(1) << OW) - SW'(1);

    logic signed [SW-1:0] c_term;
    logic signed [SW-1:0] f_term;
    logic signed [SW-1:0] total;
    logic                 over;
    logic                 under;

    always_comb begin
        c_term  = $signed({{(SW-CW){1'b0}}, coarse}) <<< SH;
        f_term  = $signed({{(SW-FW){1'b0}}, fine});
        total   = c_term + f_term - OFFS_V;
        under   = total[SW-1];
        over    = !under && (total > MAX_V);
        clamped = under || over;
        if (under) begin
            native = '0;
        end else if (over) begin
            native = '1;
        end else begin
            native = total[OW-1:0];
        end
    end
endmodule

// File: rtl/adc_merge_ctrl.sv
// Load and transfer-pulse sequencing.
module adc_merge_ctrl
    import adc_merge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic conv_stb,
    output logic load,
    output logic xfer
);
    xfer_state_t state_q;
    xfer_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = conv_stb ? ST_PULSE : ST_IDLE;
            ST_PULSE: state_d = conv_stb ? ST_PULSE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load = conv_stb;
        xfer = 1'b0;
        unique case (state_q)
            ST_IDLE:  xfer = 1'b0;
            ST_PULSE: xfer = 1'b1;
            default:  xfer = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_byte_lane.sv
// One gated output lane; data reads zero while the lane is released.
module adc_byte_lane #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          en_n,
    output logic [DW-1:0] lane,
    output logic          oe
);
    always_comb begin
        oe   = !en_n;
        lane = oe ? data : '0;
    end
endmodule

// File: rtl/adc_subrange_merge.sv
module adc_subrange_merge #(
    parameter int CW = 9,
    parameter int FW = 9,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          conv_stb,
    input  logic [CW-1:0] coarse_code,
    input  logic [FW-1:0] fine_code,
    input  logic          twos_sel,
    input  logic          hi_en_n,
    input  logic          lo_en_n,
    output logic [OW-1:0] result,
    output logic          msb_cmp,
    output logic          ovr_n,
    output logic          xfer_pulse,
    output logic [OW/2:0] hi_lane,
    output logic          hi_oe,
    output logic [OW/2-1:0] lo_lane,
    output logic          lo_oe
);
    localparam int HB = OW / 2;

    logic [OW-1:0] native;
    logic          clamped;
    logic          load;
    logic [OW-1:0] coded;

    adc_merge_sum #(.CW(CW), .FW(FW), .OW(OW)) u_sum (
        .coarse (coarse_code),
        .fine   (fine_code),
        .native (native),
        .clamped(clamped)
    );

    adc_merge_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .conv_stb(conv_stb),
        .load    (load),
        .xfer    (xfer_pulse)
    );

    always_comb begin
        coded = native;
        coded[OW-1] = native[OW-1] ^ twos_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            msb_cmp <= 1'b1;
            ovr_n   <= 1'b1;
        end else if (load) begin
            result  <= coded;
            msb_cmp <= !native[OW-1];
            ovr_n   <= !clamped;
        end
    end

    adc_byte_lane #(.DW(HB + 1)) u_hi (
        .data({msb_cmp, result[OW-1:HB]}),
        .en_n(hi_en_n),
        .lane(hi_lane),
        .oe  (hi_oe)
    );

    adc_byte_lane #(.DW(HB)) u_lo (
        .data(result[HB-1:0]),
        .en_n(lo_en_n),
        .lane(lo_lane),
        .oe  (lo_oe)
    );
endmodule

// File: rtl/adc_merge_chk.sv
module adc_merge_chk #(
    parameter int CW = 9,
    parameter int FW = 9,
    parameter int OW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_stb,
    input logic [CW-1:0] coarse_code,
    input logic [OW-1:0] result,
    input logic          msb_cmp,
    input logic          ovr_n,
    input logic          xfer_pulse,
    input logic          hi_en_n,
    input logic          lo_en_n,
    input logic [OW/2:0] hi_lane,
    input logic          hi_oe,
    input logic [OW/2-1:0] lo_lane,
    input logic          lo_oe
);
    localparam int SH = OW - CW;
    localparam int SAFE_HI = ((1 << OW) - 1 - ((1 << FW) - 1) + (1 << SH)) >> SH;

    logic [OW-1:0] nat_w;
    assign nat_w = {!msb_cmp, result[OW-2:0]};

    assert_clamp_value_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_n |-> (nat_w == '0 || nat_w == '1));

    assert_safe_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_stb && coarse_code >= CW'(1) && coarse_code <= CW'(SAFE_HI)) |=> ovr_n);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_stb |=> ($stable(result) && $stable(msb_cmp) && $stable(ovr_n)));

    assert_pulse_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_stb |=> xfer_pulse);

    assert_no_stray_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_stb |=> !xfer_pulse);

    assert_hi_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hi_en_n |-> (!hi_oe && hi_lane == '0));

    assert_lo_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lo_en_n |-> (!lo_oe && lo_lane == '0));
endmodule

bind adc_subrange_merge adc_merge_chk #(.CW(CW), .FW(FW), .OW(OW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_stb   (conv_stb),
    .coarse_code(coarse_code),
    .result     (result),
    .msb_cmp    (msb_cmp),
    .ovr_n      (ovr_n),
    .xfer_pulse (xfer_pulse),
    .hi_en_n    (hi_en_n),
    .lo_en_n    (lo_en_n),
    .hi_lane    (hi_lane),
    .hi_oe      (hi_oe),
    .lo_lane    (lo_lane),
    .lo_oe      (lo_oe)
);

// File: tb/adc_subrange_merge_bench.sv
module adc_subrange_merge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_stb = 1'b0;
    logic [8:0]  coarse_code = '0;
    logic [8:0]  fine_code = '0;
    logic        twos_sel = 1'b0;
    logic        hi_en_n = 1'b1;
    logic        lo_en_n = 1'b1;
    logic [15:0] result;
    logic        msb_cmp;
    logic        ovr_n;
    logic        xfer_pulse;
    logic [8:0]  hi_lane;
    logic        hi_oe;
    logic [7:0]  lo_lane;
    logic        lo_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_subrange_merge u_adc_subrange_merge (
        .clk(clk), .rst_n(rst_n), .conv_stb(conv_stb),
        .coarse_code(coarse_code), .fine_code(fine_code), .twos_sel(twos_sel),
        .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .result(result), .msb_cmp(msb_cmp),
        .ovr_n(ovr_n), .xfer_pulse(xfer_pulse), .hi_lane(hi_lane), .hi_oe(hi_oe),
        .lo_lane(lo_lane), .lo_oe(lo_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic convert(input int c, input int f, input bit tw, input bit he, input bit le);
        int s;
        logic [15:0] nat;
        logic [15:0] cod;
        bit clampv;
        s = c * 128 + f - 128;
        clampv = (s < 0) || (s > 65535);
        nat = (s < 0) ? 16'h0000 : (s > 65535) ? 16'hFFFF : 16'(s);
        cod = nat ^ (tw ? 16'h8000 : 16'h0000);
        @(negedge clk);
        conv_stb = 1'b1; coarse_code = 9'(c); fine_code = 9'(f); twos_sel = tw;
        hi_en_n = he; lo_en_n = le;
        @(negedge clk);
        conv_stb = 1'b0;
        if (s > 65535)      chk("R2 word", 32'(nat), 32'hFFFF);
        else if (s < 0)     chk("R3 word", 32'(nat), 32'h0000);
        chk("R1/R5 result", 32'(result), 32'(cod));
        chk("R6 msb_cmp", 32'(msb_cmp), 32'(!nat[15]));
        chk("R2/R3/R4 ovr_n", 32'(ovr_n), 32'(!clampv));
        chk("R8 xfer high", 32'(xfer_pulse), 32'd1);
        chk("R9 hi_oe", 32'(hi_oe), 32'(!he));
        chk("R9 hi_lane", 32'(hi_lane), he ? 32'd0 : 32'({!nat[15], cod[15:8]}));
        chk("R10 lo_oe", 32'(lo_oe), 32'(!le));
        chk("R10 lo_lane", 32'(lo_lane), le ? 32'd0 : 32'(cod[7:0]));
        coarse_code = ~coarse_code; fine_code = ~fine_code; twos_sel = !tw;
        @(negedge clk);
        chk("R7 hold result", 32'(result), 32'(cod));
        chk("R7 hold ovr_n", 32'(ovr_n), 32'(!clampv));
        chk("R8 xfer low", 32'(xfer_pulse), 32'd0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int fines[12];
        fines = '{0, 1, 127, 128, 129, 255, 256, 383, 384, 510, 511, 0};
        repeat (3) @(negedge clk);
        chk("R11 result", 32'(result), 32'h0);
        chk("R11 msb_cmp", 32'(msb_cmp), 32'd1);
        chk("R11 ovr_n", 32'(ovr_n), 32'd1);
        chk("R11 xfer", 32'(xfer_pulse), 32'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 512; c++) begin
            for (int k = 0; k < 12; k++) begin
                int f;
                f = (k == 11) ? ((c * 37 + 5) % 512) : fines[k];
                convert(c, f, bit'((c ^ k) & 1), bit'((c + k) % 3 == 0), bit'(k % 4 == 1));
            end
        end
        // R4 exact boundaries: sums 0 and 65535
        convert(1, 0, 1'b0, 1'b0, 1'b0);
        convert(509, 511, 1'b1, 1'b0, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule